// File: doc/BRIEF.md
# Transmit Descriptor Fetch Engine

This block walks a ring of transmit descriptors held in memory and turns the buffers they point at into a byte stream for a MAC transmitter. Software builds the descriptors, sets a queue base address, and pulses a start command while transmission is enabled. The engine then fetches descriptors one after another from the base. Each descriptor it owns contributes its buffer's bytes to the current frame, and a frame closes at the first buffer flagged as the frame's last.

When a frame closes, the engine writes the used flag into the control word of the frame's first descriptor and sets a sticky frame-done flag. It then moves on to the next descriptor. A descriptor whose used flag is already set means the ring holds nothing more to send, and the engine goes idle there.

If that marker turns up while a frame is still open, the frame is abandoned. The engine flags the frame's first descriptor as buffers-exhausted and raises a sticky error flag. Memory is reached through a single word port with a request/ready handshake. The bytes leave on a valid/ready stream with an end-of-frame marker.

Top module: `txq_fetch_engine`

## Requirements
- R1: While reset is held and right after it, there is no memory request and no stream valid, and both status flags are clear.
- R2: A start pulse is taken only while the engine is idle and transmit enable is high; with enable low a start causes no memory access at all.
- R3: A descriptor is two words at consecutive word addresses, read in order: word 0 at the descriptor address holds the buffer byte address, and word 1 at address+4 holds control, with bits 10:0 the buffer length in bytes and bit 15 the last-buffer-of-frame flag. Every start fetches its first descriptor from the queue base.
- R4: A buffer's bytes leave in ascending address order, little-endian within each memory word (byte at address a is bits 8*(a mod 4)+7 down to 8*(a mod 4)). The buffer may start at any byte alignment, and a zero-length buffer adds no bytes.
- R5: A frame is the concatenation of its buffers up to and including the one with bit 15 set. The end-of-frame marker accompanies only the final byte of that buffer.
- R6: When a frame ends, word 1 of the frame's first descriptor is rewritten with bit 31 (used) set and all other bits unchanged. After that the frame-done flag is set.
- R7: A descriptor with bit 31 set, met at a frame boundary, stops the engine with no write and no flag change.
- R8: After a descriptor whose bit 30 (wrap) is set, the next descriptor is fetched from the queue base.
- R9: A descriptor with bit 31 set, met after a buffer of an unfinished frame, aborts the frame. Word 1 of the frame's first descriptor is written with bits 31 and 27 set and the other bits unchanged, the exhausted flag is set, the done flag is left alone, and the engine goes idle.
- R10: Each status flag stays set until a one is applied to its own clear input.
- R11: The stream holds data and marker while valid is high and ready is low. The memory port holds address, direction and write data while a request waits for ready.
- R12: Every memory address issued is word aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_tx_enable | input | 1 | Transmit enable; gates start |
| ctl_start | input | 1 | Start command pulse |
| queue_base | input | ADDR_W | Byte address of the first descriptor, 8-byte aligned |
| stat_done_clr | input | 1 | Write-one clear of the frame-done flag |
| stat_err_clr | input | 1 | Write-one clear of the exhausted flag |
| stat_frame_done | output | 1 | Sticky: a frame completed |
| stat_exhausted | output | 1 | Sticky: a frame was aborted by a stop marker |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Request accepted; read data valid this cycle |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Stream byte valid |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of frame |
| tx_ready | input | 1 | Stream sink ready |

## Verification
The hardest case to reach from the ports is the mid-frame abort. The engine must already have streamed part of a frame before it meets a used descriptor, and the abort write-back must land on the first descriptor, not the current one. The stimulus builds a two-buffer chain with no last flag followed by a stop marker, and runs it under random ready on both the stream and memory. A second hard case is the wrap back onto a descriptor the engine itself has just marked used. The stimulus builds a ring whose second entry wraps, so the engine's own write-back becomes the stop marker.

// File: rtl/txq_pkg.sv
// Shared constants and state types for the transmit descriptor engine.
// Assumes 32-bit descriptor words; control-word bit positions are fixed by
// the software-visible descriptor layout.
package txq_pkg;
    localparam int unsigned DW           = 32;
    localparam int unsigned LEN_W        = 11;
    localparam int unsigned BIT_LAST_BUF = 15;
    localparam int unsigned BIT_EXHAUST  = 27;
    localparam int unsigned BIT_WRAP     = 30;
    localparam int unsigned BIT_USED     = 31;

    localparam logic [DW-1:0] MASK_USED    = DW'(1) << BIT_USED;
    localparam logic [DW-1:0] MASK_EXHAUST = DW'(1) << BIT_EXHAUST;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_ADDR,
        SEQ_CTRL,
        SEQ_BUFFER,
        SEQ_CLOSE,
        SEQ_ABORT
    } seq_state_t;

    typedef enum logic [1:0] {
        STR_IDLE,
        STR_FETCH,
        STR_EMIT
    } str_state_t;
endpackage

// File: rtl/txq_byte_streamer.sv
// Byte streamer: given a buffer byte address and length, reads the covering
// memory words and emits the bytes one per handshake, little-endian within a
// word. Assumes read data is valid in the cycle ready is high. Pulses done_o
// one cycle after the last byte is taken (or after start for a zero length).
module txq_byte_streamer #(
    parameter int unsigned ADDR_W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic [ADDR_W-1:0]         buf_addr_i,
    input  logic [txq_pkg::LEN_W-1:0] len_i,
    input  logic                      eof_i,
    output logic                      done_o,
    output logic                      rd_req_o,
    output logic [ADDR_W-1:0]         rd_addr_o,
    input  logic                      rd_ready_i,
    input  logic [txq_pkg::DW-1:0]    rd_data_i,
    output logic                      out_valid_o,
    output logic [7:0]                out_data_o,
    output logic                      out_last_o,
    input  logic                      out_ready_i
);
    import txq_pkg::*;

    localparam int unsigned LANE_W = $clog2(DW / 8);

    str_state_t        st_q;
    logic [ADDR_W-1:0] cur_q;
    logic [LEN_W-1:0]  left_q;
    logic [DW-1:0]     word_q;
    logic              eof_q;
    logic              done_q;
    logic              fin_byte;
    logic              lane_end;

    assign fin_byte = (left_q == LEN_W'(1));
    assign lane_end = (cur_q[LANE_W-1:0] == {LANE_W{1'b1}});

    // Purpose: walk the buffer, refilling the word register at each word boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= STR_IDLE;
            cur_q  <= '0;
            left_q <= '0;
            word_q <= '0;
            eof_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st_q)
                STR_IDLE: begin
                    if (start_i) begin
                        cur_q  <= buf_addr_i;
                        left_q <= len_i;
                        eof_q  <= eof_i;
                        if (len_i == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            st_q <= STR_FETCH;
                        end
                    end
                end
                STR_FETCH: begin
                    if (rd_ready_i) begin
                        word_q <= rd_data_i;
                        st_q   <= STR_EMIT;
                    end
                end
                STR_EMIT: begin
                    if (out_ready_i) begin
                        cur_q  <= cur_q + ADDR_W'(1);
                        left_q <= left_q - LEN_W'(1);
                        if (fin_byte) begin
                            st_q   <= STR_IDLE;
                            done_q <= 1'b1;
                        end else if (lane_end) begin
                            st_q <= STR_FETCH;
                        end
                    end
                end
                default: st_q <= STR_IDLE;
            endcase
        end
    end

    // Purpose: drive the word read and the byte stream from the current state.
    always_comb begin
        rd_req_o    = (st_q == STR_FETCH);
        rd_addr_o   = {cur_q[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
        out_valid_o = (st_q == STR_EMIT);
        out_data_o  = word_q[{cur_q[LANE_W-1:0], 3'b000} +: 8];
        out_last_o  = (st_q == STR_EMIT) && eof_q && fin_byte;
    end

    assign done_o = done_q;
endmodule

// File: rtl/txq_status.sv
// Sticky status flags with write-one-to-clear inputs. A set in the same
// cycle as a clear wins, so no event is lost.
module txq_status (
    input  logic clk,
    input  logic rst_n,
    input  logic done_set_i,
    input  logic err_set_i,
    input  logic done_clr_i,
    input  logic err_clr_i,
    output logic done_o,
    output logic err_o
);
    logic done_q;
    logic err_q;

    // Purpose: hold each flag until its clear input is pulsed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (done_set_i)      done_q <= 1'b1;
            else if (done_clr_i) done_q <= 1'b0;
            if (err_set_i)       err_q  <= 1'b1;
            else if (err_clr_i)  err_q  <= 1'b0;
        end
    end

    assign done_o = done_q;
    assign err_o  = err_q;
endmodule

// File: rtl/txq_fetch_engine.sv
// Transmit descriptor fetch engine. Sequences descriptor reads from the queue
// base, hands owned buffers to the byte streamer, writes the used flag back to
// the first descriptor of each frame and reports completion or mid-frame
// exhaustion. Assumes queue_base and descriptors are 8-byte aligned and the
// memory returns read data in the cycle it asserts ready.
module txq_fetch_engine #(
    parameter int unsigned ADDR_W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ctl_tx_enable,
    input  logic                   ctl_start,
    input  logic [ADDR_W-1:0]      queue_base,
    input  logic                   stat_done_clr,
    input  logic                   stat_err_clr,
    output logic                   stat_frame_done,
    output logic                   stat_exhausted,
    output logic                   mem_req,
    output logic                   mem_we,
    output logic [ADDR_W-1:0]      mem_addr,
    output logic [txq_pkg::DW-1:0] mem_wdata,
    input  logic                   mem_ready,
    input  logic [txq_pkg::DW-1:0] mem_rdata,
    output logic                   tx_valid,
    output logic [7:0]             tx_data,
    output logic                   tx_last,
    input  logic                   tx_ready
);
    import txq_pkg::*;

    localparam int unsigned DESC_BYTES = 2 * (DW / 8);
    localparam int unsigned DESC_LSB   = $clog2(DESC_BYTES);
    localparam logic [ADDR_W-1:0] CTRL_OFS = ADDR_W'(DW / 8);

    seq_state_t        state_q;
    logic [ADDR_W-1:0] ptr_q;
    logic [ADDR_W-1:0] buf_q;
    logic [ADDR_W-1:0] first_q;
    logic [DW-1:0]     first_ctrl_q;
    logic              last_q;
    logic              in_frame_q;

    logic [ADDR_W-1:0] base_al;
    logic              start_take;
    logic              ctrl_hit;
    logic              desc_used;
    logic              str_start;
    logic              str_done;
    logic              str_req;
    logic [ADDR_W-1:0] str_addr;
    logic              seq_req;
    logic              seq_we;
    logic [ADDR_W-1:0] seq_addr;
    logic [DW-1:0]     seq_wdata;
    logic              done_set;
    logic              err_set;

    assign base_al    = {queue_base[ADDR_W-1:DESC_LSB], {DESC_LSB{1'b0}}};
    assign start_take = (state_q == SEQ_IDLE) && ctl_start && ctl_tx_enable;
    assign ctrl_hit   = (state_q == SEQ_CTRL) && mem_ready;
    assign desc_used  = mem_rdata[BIT_USED];
    assign str_start  = ctrl_hit && !desc_used;
    assign done_set   = (state_q == SEQ_CLOSE) && mem_ready;
    assign err_set    = (state_q == SEQ_ABORT) && mem_ready;

    // Purpose: descriptor sequencing, pointer advance and frame bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= SEQ_IDLE;
            ptr_q        <= '0;
            buf_q        <= '0;
            first_q      <= '0;
            first_ctrl_q <= '0;
            last_q       <= 1'b0;
            in_frame_q   <= 1'b0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (start_take) begin
                        ptr_q   <= base_al;
                        state_q <= SEQ_ADDR;
                    end
                end
                SEQ_ADDR: begin
                    if (mem_ready) begin
                        buf_q   <= mem_rdata[ADDR_W-1:0];
                        state_q <= SEQ_CTRL;
                    end
                end
                SEQ_CTRL: begin
                    if (mem_ready) begin
                        if (desc_used) begin
                            state_q <= in_frame_q ? SEQ_ABORT : SEQ_IDLE;
                        end else begin
                            last_q <= mem_rdata[BIT_LAST_BUF];
                            if (!in_frame_q) begin
                                first_q      <= ptr_q;
                                first_ctrl_q <= mem_rdata;
                                in_frame_q   <= 1'b1;
                            end
                            ptr_q   <= mem_rdata[BIT_WRAP] ? base_al
                                                           : ptr_q + ADDR_W'(DESC_BYTES);
                            state_q <= SEQ_BUFFER;
                        end
                    end
                end
                SEQ_BUFFER: begin
                    if (str_done) begin
                        state_q <= last_q ? SEQ_CLOSE : SEQ_ADDR;
                    end
                end
                SEQ_CLOSE: begin
                    if (mem_ready) begin
                        in_frame_q <= 1'b0;
                        state_q    <= SEQ_ADDR;
                    end
                end
                SEQ_ABORT: begin
                    if (mem_ready) begin
                        in_frame_q <= 1'b0;
                        state_q    <= SEQ_IDLE;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    // Purpose: memory request of the sequencer for fetches and write-backs.
    always_comb begin
        seq_req   = 1'b0;
        seq_we    = 1'b0;
        seq_addr  = ptr_q;
        seq_wdata = '0;
        case (state_q)
            SEQ_ADDR: seq_req = 1'b1;
            SEQ_CTRL: begin
                seq_req  = 1'b1;
                seq_addr = ptr_q + CTRL_OFS;
            end
            SEQ_CLOSE: begin
                seq_req   = 1'b1;
                seq_we    = 1'b1;
                seq_addr  = first_q + CTRL_OFS;
                seq_wdata = first_ctrl_q | MASK_USED;
            end
            SEQ_ABORT: begin
                seq_req   = 1'b1;
                seq_we    = 1'b1;
                seq_addr  = first_q + CTRL_OFS;
                seq_wdata = first_ctrl_q | MASK_USED | MASK_EXHAUST;
            end
            default: ;
        endcase
    end

    // Purpose: merge sequencer and streamer onto the single memory port.
    always_comb begin
        mem_req   = seq_req | str_req;
        mem_we    = seq_we;
        mem_addr  = str_req ? str_addr : seq_addr;
        mem_wdata = seq_wdata;
    end

    txq_byte_streamer #(
        .ADDR_W (ADDR_W)
    ) streamer_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (str_start),
        .buf_addr_i  (buf_q),
        .len_i       (mem_rdata[LEN_W-1:0]),
        .eof_i       (mem_rdata[BIT_LAST_BUF]),
        .done_o      (str_done),
        .rd_req_o    (str_req),
        .rd_addr_o   (str_addr),
        .rd_ready_i  (mem_ready),
        .rd_data_i   (mem_rdata),
        .out_valid_o (tx_valid),
        .out_data_o  (tx_data),
        .out_last_o  (tx_last),
        .out_ready_i (tx_ready)
    );

    txq_status status_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .done_set_i (done_set),
        .err_set_i  (err_set),
        .done_clr_i (stat_done_clr),
        .err_clr_i  (stat_err_clr),
        .done_o     (stat_frame_done),
        .err_o      (stat_exhausted)
    );
endmodule

// File: rtl/txq_fetch_engine_chk.sv
// Port-level protocol checker for the transmit descriptor engine, bound to
// every instance of the top module.
module txq_fetch_engine_chk #(
    parameter int unsigned ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stat_frame_done,
    input logic              stat_exhausted,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [31:0]       mem_wdata,
    input logic              mem_ready,
    input logic              tx_valid,
    input logic [7:0]        tx_data,
    input logic              tx_last,
    input logic              tx_ready
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!mem_req && !tx_valid && !stat_frame_done && !stat_exhausted));

    assert_stream_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

    assert_mem_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=>
            (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    assert_word_align_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    assert_wb_used_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> mem_wdata[31]);

    assert_done_after_wb_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_frame_done) |-> $past(mem_req && mem_we && mem_ready && !mem_wdata[27]));

    assert_err_after_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_exhausted) |-> $past(mem_req && mem_we && mem_ready && mem_wdata[27]));
endmodule

bind txq_fetch_engine txq_fetch_engine_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .stat_frame_done (stat_frame_done),
    .stat_exhausted  (stat_exhausted),
    .mem_req         (mem_req),
    .mem_we          (mem_we),
    .mem_addr        (mem_addr),
    .mem_wdata       (mem_wdata),
    .mem_ready       (mem_ready),
    .tx_valid        (tx_valid),
    .tx_data         (tx_data),
    .tx_last         (tx_last),
    .tx_ready        (tx_ready)
);

// File: tb/txq_fetch_engine_tb_top.sv
// Bench: behavioural memory plus queues of expected stream bytes and expected
// write-backs, compared on every clock where a handshake completes.
module txq_fetch_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        ctl_tx_enable;
    logic        ctl_start;
    logic [31:0] queue_base;
    logic        stat_done_clr;
    logic        stat_err_clr;
    logic        stat_frame_done;
    logic        stat_exhausted;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ready;
    logic [31:0] mem_rdata;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_last;
    logic        tx_ready;

    always #10 clk = ~clk;

    txq_fetch_engine #(.ADDR_W(32)) dut_i (
        .clk(clk), .rst_n(rst_n), .ctl_tx_enable(ctl_tx_enable), .ctl_start(ctl_start),
        .queue_base(queue_base), .stat_done_clr(stat_done_clr), .stat_err_clr(stat_err_clr),
        .stat_frame_done(stat_frame_done), .stat_exhausted(stat_exhausted),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready)
    );

    logic [31:0] mem [0:255];
    assign mem_rdata = mem[mem_addr[9:2]];

    logic [8:0]  exp_by [$];
    logic [63:0] exp_wr [$];
    logic [31:0] rd_log [$];
    integer checks = 0;
    integer fails  = 0;
    integer activity = 0;
    bit     stall_on = 1'b0;
    logic [15:0] lf = 16'hACE1;
    logic        pv_tv = 1'b0, pv_tr = 1'b0, pv_mq = 1'b0, pv_mr = 1'b0;
    logic [8:0]  pv_td = '0;
    logic [31:0] pv_ma = '0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] byte_at(input int a);
        logic [31:0] w;
        w = mem[a / 4];
        return w[8 * (a % 4) +: 8];
    endfunction

    function automatic logic [31:0] ctrl(input int len, input bit last, input bit wrap, input bit used);
        return 32'(len) | (32'(last) << 15) | (32'(wrap) << 30) | (32'(used) << 31);
    endfunction

    task automatic put_desc(input int slot, input int bufa, input logic [31:0] cw);
        mem[slot / 4]       = 32'(bufa);
        mem[(slot + 4) / 4] = cw;
    endtask

    task automatic expect_buf(input int bufa, input int n, input bit eof);
        for (int i = 0; i < n; i++)
            exp_by.push_back({eof && (i == n - 1), byte_at(bufa + i)});
    endtask

    // Purpose: drive ready inputs, then score the handshakes of the coming edge.
    always @(negedge clk) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        tx_ready  = stall_on ? lf[0] : 1'b1;
        mem_ready = stall_on ? lf[3] : 1'b1;
        #1;
        if (rst_n === 1'b1) begin
            if (mem_req) begin
                activity++;
                chk(mem_addr[1:0] == 2'b00, "R12 word-aligned address", mem_addr, {mem_addr[31:2], 2'b00});
            end
            if (pv_tv && !pv_tr)
                chk(tx_valid && ({tx_last, tx_data} == pv_td), "R11 stream hold", {tx_valid, tx_last, tx_data}, {1'b1, pv_td});
            if (pv_mq && !pv_mr)
                chk(mem_req && (mem_addr == pv_ma), "R11 memory hold", {mem_req, mem_addr}, {1'b1, pv_ma});
            if (tx_valid && tx_ready) begin
                if (exp_by.size() == 0) chk(1'b0, "R4/R5 unexpected byte", {tx_last, tx_data}, 0);
                else begin
                    logic [8:0] e;
                    e = exp_by.pop_front();
                    chk({tx_last, tx_data} == e, "R4/R5 stream byte", {tx_last, tx_data}, e);
                end
            end
            if (mem_req && mem_ready && !mem_we) rd_log.push_back(mem_addr);
            if (mem_req && mem_ready && mem_we) begin
                if (exp_wr.size() == 0) chk(1'b0, "R6/R9 unexpected write", {mem_addr, mem_wdata}, 0);
                else begin
                    logic [63:0] e;
                    e = exp_wr.pop_front();
                    chk({mem_addr, mem_wdata} == e, "R6/R9 write-back", {mem_addr, mem_wdata}, e);
                end
                mem[mem_addr[9:2]] = mem_wdata;
            end
        end
        pv_tv = tx_valid; pv_tr = tx_ready; pv_td = {tx_last, tx_data};
        pv_mq = mem_req;  pv_mr = mem_ready; pv_ma = mem_addr;
    end

    task automatic kick(input logic [31:0] base);
        @(negedge clk);
        queue_base = base;
        ctl_start  = 1'b1;
        @(negedge clk);
        ctl_start  = 1'b0;
    endtask

    task automatic wait_quiet();
        int n = 0;
        while (n < 10) begin
            @(negedge clk);
            #2;
            if (!mem_req && !tx_valid) n++;
            else n = 0;
        end
    endtask

    task automatic pulse_clr(input bit done_c, input bit err_c);
        @(negedge clk);
        stat_done_clr = done_c;
        stat_err_clr  = err_c;
        @(negedge clk);
        stat_done_clr = 1'b0;
        stat_err_clr  = 1'b0;
        #2;
    endtask

    task automatic drained(input string tag);
        chk(exp_by.size() == 0, {tag, " all bytes sent"}, exp_by.size(), 0);
        chk(exp_wr.size() == 0, {tag, " all writes seen"}, exp_wr.size(), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int w = 0; w < 256; w++)
            mem[w] = (w < 64) ? 32'h0 : ((32'(w) * 32'h0105_0B17) ^ 32'hA5C3_1E77);
        rst_n = 1'b0; ctl_tx_enable = 1'b1; ctl_start = 1'b0; queue_base = '0;
        stat_done_clr = 1'b0; stat_err_clr = 1'b0;
        repeat (4) @(negedge clk);
        #2;
        chk(!mem_req && !tx_valid && !stat_frame_done && !stat_exhausted, "R1 state in reset",
            {mem_req, tx_valid, stat_frame_done, stat_exhausted}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        #2;
        chk(!mem_req && !tx_valid && !stat_frame_done && !stat_exhausted, "R1 idle after reset",
            {mem_req, tx_valid, stat_frame_done, stat_exhausted}, 0);

        // R2: start ignored with transmit enable low
        ctl_tx_enable = 1'b0;
        put_desc(32'h00, 32'h100, ctrl(5, 1, 0, 0));
        activity = 0;
        kick(32'h0);
        repeat (20) @(negedge clk);
        #2;
        chk(activity == 0, "R2 no access with enable low", activity, 0);
        chk(!stat_frame_done, "R2 no frame with enable low", stat_frame_done, 0);
        ctl_tx_enable = 1'b1;

        // R3/R6/R7: single aligned buffer, then stop marker
        put_desc(32'h08, 32'h0, ctrl(0, 1, 1, 1));
        expect_buf(32'h100, 5, 1);
        exp_wr.push_back({32'h04, ctrl(5, 1, 0, 0) | 32'h8000_0000});
        rd_log.delete();
        kick(32'h0);
        wait_quiet();
        drained("R6 single frame");
        chk(rd_log.size() >= 2 && rd_log[0] == 32'h0 && rd_log[1] == 32'h4, "R3 fetch order from base",
            {rd_log[0], rd_log[1]}, {32'h0, 32'h4});
        chk(stat_frame_done && !stat_exhausted, "R6 done flag set", {stat_frame_done, stat_exhausted}, 2'b10);
        chk(mem[1] == 32'h8000_8005, "R6 used bit written back", mem[1], 32'h8000_8005);
        pulse_clr(1, 0);
        chk(!stat_frame_done, "R10 done cleared by write-one", stat_frame_done, 0);

        // R7: restart on a used first descriptor stops with nothing done
        rd_log.delete();
        kick(32'h0);
        wait_quiet();
        chk(rd_log.size() == 2 && rd_log[0] == 32'h0, "R7 stop at used descriptor", rd_log.size(), 2);
        chk(!stat_frame_done && !stat_exhausted, "R7 no flag change", {stat_frame_done, stat_exhausted}, 0);
        drained("R7 stop");

        // R4/R5: three buffers, odd alignment, zero-length middle, stalls
        stall_on = 1'b1;
        put_desc(32'h40, 32'h101, ctrl(3, 0, 0, 0));
        put_desc(32'h48, 32'h130, ctrl(0, 0, 0, 0));
        put_desc(32'h50, 32'h143, ctrl(6, 1, 0, 0));
        put_desc(32'h58, 32'h0, ctrl(0, 1, 1, 1));
        expect_buf(32'h101, 3, 0);
        expect_buf(32'h143, 6, 1);
        exp_wr.push_back({32'h44, ctrl(3, 0, 0, 0) | 32'h8000_0000});
        kick(32'h40);
        wait_quiet();
        drained("R5 multi-buffer frame");
        chk(stat_frame_done, "R5 multi-buffer frame done", stat_frame_done, 1);
        chk(mem[32'h54 / 4] == ctrl(6, 1, 0, 0), "R6 only first descriptor written", mem[32'h54 / 4], ctrl(6, 1, 0, 0));
        pulse_clr(1, 0);

        // R8: two frames, second wraps onto the first (now used by write-back)
        put_desc(32'h80, 32'h180, ctrl(4, 1, 0, 0));
        put_desc(32'h88, 32'h1A2, ctrl(7, 1, 1, 0));
        expect_buf(32'h180, 4, 1);
        expect_buf(32'h1A2, 7, 1);
        exp_wr.push_back({32'h84, ctrl(4, 1, 0, 0) | 32'h8000_0000});
        exp_wr.push_back({32'h8C, ctrl(7, 1, 1, 0) | 32'h8000_0000});
        rd_log.delete();
        kick(32'h80);
        wait_quiet();
        drained("R8 wrap ring");
        chk(rd_log.size() >= 2 && rd_log[rd_log.size() - 2] == 32'h80 && rd_log[rd_log.size() - 1] == 32'h84,
            "R8 fetch returns to base after wrap", rd_log[rd_log.size() - 2], 32'h80);
        chk(stat_frame_done && !stat_exhausted, "R8 frames completed", {stat_frame_done, stat_exhausted}, 2'b10);
        pulse_clr(1, 0);

        // R9: stop marker in mid frame
        put_desc(32'hC0, 32'h1C0, ctrl(5, 0, 0, 0));
        put_desc(32'hC8, 32'h1E1, ctrl(2, 0, 0, 0));
        put_desc(32'hD0, 32'h0, ctrl(0, 1, 1, 1));
        expect_buf(32'h1C0, 5, 0);
        expect_buf(32'h1E1, 2, 0);
        exp_wr.push_back({32'hC4, ctrl(5, 0, 0, 0) | 32'h8800_0000});
        kick(32'hC0);
        wait_quiet();
        drained("R9 abort");
        chk(stat_exhausted && !stat_frame_done, "R9 exhausted flag, no done", {stat_frame_done, stat_exhausted}, 2'b01);
        chk(mem[32'hCC / 4] == ctrl(2, 0, 0, 0), "R9 current descriptor untouched", mem[32'hCC / 4], ctrl(2, 0, 0, 0));
        rd_log.delete();
        kick(32'hC0);
        wait_quiet();
        chk(rd_log.size() == 2 && rd_log[0] == 32'hC0, "R9 idle after abort, restart at base", rd_log.size(), 2);
        chk(stat_exhausted, "R10 exhausted flag held", stat_exhausted, 1);
        pulse_clr(0, 1);
        chk(!stat_exhausted, "R10 exhausted cleared by write-one", stat_exhausted, 0);
        stall_on = 1'b0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule